// File: doc/BRIEF.md
# I2C-Mode Serial Event Controller

This block is the control and event logic of a serial port running in an I2C-style mode. It holds an 8-bit mode control register. It watches the bus clock and data lines through synchronisers and counts clock pulses within each byte frame. From that count it raises two interrupt request strobes, one DMA request strobe and the strobe that copies the receive shift register into the receive buffer. It also flags start and stop conditions on the bus.

One mode bit chooses what the strobes mean. With the bit cleared, the strobes report acknowledge and no-acknowledge on the ninth clock, and the buffer loads on the rising edge of that ninth clock. With the bit set, the strobes report transmit completion on the rising edge of the eighth clock and receive completion on its falling edge, and the buffer loads on that falling edge. The block also shapes the clock and data outputs: the clock can be forced low or held low after a byte, and the data output can be released to high impedance or dropped after a lost arbitration.

Top module: `i2c_event_ctl`

## Requirements
- R1: After reset `cfg_q` is 0x00, every strobe output is low, `scl_o` equals `ser_clk` and `sda_oe` is 1.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the control register, and `cfg_q` shows it from the next cycle.
- R3: With control bit 0 cleared, SDA is sampled on the rising edge of the ninth clock of a frame. SDA high there (no acknowledge) gives one `irq_a` pulse. SDA low there (acknowledge) gives one `irq_b` pulse.
- R4: With control bit 0 set, the rising edge of the eighth clock gives one `irq_a` pulse and the falling edge of the eighth clock gives one `irq_b` pulse, whatever the acknowledge value.
- R5: `dma_req` pulses only while `dma_sel` is 4'b1101. It fires on acknowledge at the ninth rising edge when bit 0 is cleared, and on the eighth falling edge when bit 0 is set.
- R6: `rx_buf` takes `rx_shift` at the ninth rising edge when bit 0 is cleared, and at the eighth falling edge when bit 0 is set.
- R7: While control bit 5 is 1, `scl_o` is 0. Otherwise it follows `ser_clk`.
- R8: While control bit 6 is 1, `sda_oe` is 0 (data line released).
- R9: With control bit 7 set, SDA falling while SCL is high gives one `start_det` pulse, and SDA rising while SCL is high gives one `stop_det` pulse. Both also restart the clock count. With bit 7 cleared, neither pulse appears.
- R10: While control bit 4 is 1, the clock count is held at zero, so a frame produces no interrupt, DMA or buffer strobe.
- R11: With control bit 2 set, the eighth falling edge latches a wait that holds `scl_o` at 0 until bit 2 is cleared.
- R12: With control bit 3 set, a clock rising edge that finds SDA low while `tx_bit` is 1 drops `sda_oe` to 0 until bit 3 is cleared.
- R13: Each request and condition output is a pulse exactly one system cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_q | output | 8 | Control register contents |
| ser_clk | input | 1 | Serial clock from the port's clock generator |
| tx_bit | input | 1 | Data bit the port is sending |
| scl_in | input | 1 | Sampled SCL line (asynchronous) |
| sda_in | input | 1 | Sampled SDA line (asynchronous) |
| rx_shift | input | 8 | Receive shift register contents |
| dma_sel | input | 4 | DMA request source selection |
| scl_o | output | 1 | Clock output level |
| sda_o | output | 1 | Data output level |
| sda_oe | output | 1 | Data output enable |
| irq_a | output | 1 | First interrupt request strobe |
| irq_b | output | 1 | Second interrupt request strobe |
| dma_req | output | 1 | DMA request strobe |
| start_det | output | 1 | Start condition strobe |
| stop_det | output | 1 | Stop condition strobe |
| rx_buf | output | 8 | Receive buffer |

## Verification
A clock count that has drifted by even one pulse shows up within one frame. The receive buffer then captures the shift register before or after it changes between the eighth and ninth clocks, and the acknowledge strobe follows the wrong bit of data. A wrong mode decode swaps the interrupt strobes or moves the buffer load by half a clock period, and both show at the ports about three system cycles after the clock edge concerned. A wait or arbitration flag that latches wrongly shows at once on `scl_o` or `sda_oe` and stays until its control bit is cleared.

// File: rtl/i2c_event_ctl.sv
module i2c_event_ctl #(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2,
  parameter int SEL_W = 4,
  parameter logic [SEL_W-1:0] DMA_CODE = 4'b1101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_q,
  input  logic              ser_clk,
  input  logic              tx_bit,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [DATA_W-1:0] rx_shift,
  input  logic [SEL_W-1:0]  dma_sel,
  output logic              scl_o,
  output logic              sda_o,
  output logic              sda_oe,
  output logic              irq_a,
  output logic              irq_b,
  output logic              dma_req,
  output logic              start_det,
  output logic              stop_det,
  output logic [DATA_W-1:0] rx_buf
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACKC = CNT_W'(DATA_W + 1);

  logic [7:0]        ctl;
  logic [SYNC_N:0]   scl_sh, sda_sh;
  logic [CNT_W-1:0]  cnt;
  logic              wait_q, arb_q;

  wire mode    = ctl[0];
  wire wait_en = ctl[2];
  wire arb_en  = ctl[3];
  wire init    = ctl[4];
  wire scl_lo  = ctl[5];
  wire sda_off = ctl[6];
  wire cond_en = ctl[7];

  wire scl_s = scl_sh[SYNC_N-1];
  wire scl_p = scl_sh[SYNC_N];
  wire sda_s = sda_sh[SYNC_N-1];
  wire sda_p = sda_sh[SYNC_N];

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire sda_rise = sda_s & ~sda_p;
  wire sda_fall = ~sda_s & sda_p;
  wire scl_high = scl_s & scl_p;

  wire start_c = cond_en & sda_fall & scl_high;
  wire stop_c  = cond_en & sda_rise & scl_high;

  wire rise_last = scl_rise && (cnt == PRE);
  wire fall_last = scl_fall && (cnt == LAST);
  wire rise_ack  = scl_rise && (cnt == LAST);

  wire irq_a_n = mode ? rise_last : (rise_ack & sda_s);
  wire irq_b_n = mode ? fall_last : (rise_ack & ~sda_s);
  wire load_n  = mode ? fall_last : rise_ack;
  wire dma_n   = (dma_sel == DMA_CODE) & (mode ? fall_last : (rise_ack & ~sda_s));

  assign cfg_q  = ctl;
  assign scl_o  = ser_clk & ~scl_lo & ~wait_q;
  assign sda_o  = tx_bit;
  assign sda_oe = ~sda_off & ~arb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      if (cfg_we) ctl <= cfg_wdata;
      scl_sh <= {scl_sh[SYNC_N-1:0], scl_in};
      sda_sh <= {sda_sh[SYNC_N-1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (init || start_c || stop_c) cnt <= '0;
    else if (scl_rise && cnt != ACKC)   cnt <= cnt + 1'b1;
    else if (scl_fall && cnt == ACKC)   cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_a     <= 1'b0;
      irq_b     <= 1'b0;
      dma_req   <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      rx_buf    <= '0;
    end else begin
      irq_a     <= irq_a_n;
      irq_b     <= irq_b_n;
      dma_req   <= dma_n;
      start_det <= start_c;
      stop_det  <= stop_c;
      if (load_n) rx_buf <= rx_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      arb_q  <= 1'b0;
    end else begin
      if (!wait_en)       wait_q <= 1'b0;
      else if (fall_last) wait_q <= 1'b1;
      if (!arb_en)                               arb_q <= 1'b0;
      else if (scl_rise && tx_bit && !sda_s)     arb_q <= 1'b1;
    end
  end

  p_irq_a_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n) irq_a |=> !irq_a);
  p_irq_b_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n) irq_b |=> !irq_b);
  p_irq_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) !(irq_a && irq_b));
  p_dma_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(dma_sel) == DMA_CODE);
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n) cnt <= ACKC);
  p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n) start_det |-> cnt == '0);
  p_init_hold_r10: assert property (@(posedge clk) disable iff (!rst_n) init |=> cnt == '0);
endmodule

// File: tb/i2c_event_ctl_tb_top.sv
`timescale 1ns/1ps
module i2c_event_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_q;
  logic ser_clk = 1'b1, tx_bit = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic [7:0] rx_shift = '0, rx_buf;
  logic [3:0] dma_sel = '0;
  logic scl_o, sda_o, sda_oe, irq_a, irq_b, dma_req, start_det, stop_det;

  int checks = 0, errors = 0;
  int na, nb, nd, nst, nsp, wid;
  logic pa, pb, pd, pst, psp;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_event_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .ser_clk(ser_clk), .tx_bit(tx_bit), .scl_in(scl_in), .sda_in(sda_in),
    .rx_shift(rx_shift), .dma_sel(dma_sel), .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe),
    .irq_a(irq_a), .irq_b(irq_b), .dma_req(dma_req), .start_det(start_det),
    .stop_det(stop_det), .rx_buf(rx_buf));

  always @(negedge clk) begin
    if (rst_n) begin
      na += int'(irq_a); nb += int'(irq_b); nd += int'(dma_req);
      nst += int'(start_det); nsp += int'(stop_det);
      wid += int'((irq_a & pa) | (irq_b & pb) | (dma_req & pd) | (start_det & pst) | (stop_det & psp));
    end
    pa = irq_a; pb = irq_b; pd = dma_req; pst = start_det; psp = stop_det;
  end

  function automatic int exp_a(bit m, bit ack); return m ? 1 : (ack ? 0 : 1); endfunction
  function automatic int exp_b(bit m, bit ack); return m ? 1 : int'(ack); endfunction
  function automatic int exp_d(bit m, bit ack, logic [3:0] sel);
    return (sel == 4'b1101) ? (m ? 1 : int'(ack)) : 0;
  endfunction
  function automatic logic [7:0] exp_buf(bit m, logic [7:0] a, logic [7:0] b);
    return m ? a : b;
  endfunction

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    na = 0; nb = 0; nd = 0; nst = 0; nsp = 0; wid = 0;
  endtask

  task automatic wr(logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v; tick(1); cfg_we = 1'b0; tick(1);
  endtask

  task automatic clock_pulse();
    tick(4); scl_in = 1'b1; tick(8); scl_in = 1'b0; tick(4);
  endtask

  task automatic do_start();
    sda_in = 1'b1; tick(4); scl_in = 1'b1; tick(6); sda_in = 1'b0; tick(6); scl_in = 1'b0; tick(4);
  endtask

  task automatic do_stop();
    sda_in = 1'b0; tick(4); scl_in = 1'b1; tick(6); sda_in = 1'b1; tick(8);
  endtask

  task automatic send_byte(logic [7:0] d, bit ack, logic [7:0] a, logic [7:0] b);
    rx_shift = a;
    for (int i = 7; i >= 0; i--) begin
      sda_in = d[i];
      clock_pulse();
    end
    tick(6); rx_shift = b;
    sda_in = ~ack;
    clock_pulse();
    tick(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    clr();
    tick(3); rst_n = 1'b1; tick(2);
    // R1 reset state
    chk("R1 cfg_q", int'(cfg_q), 0);
    chk("R1 scl_o", int'(scl_o), 1);
    chk("R1 sda_oe", int'(sda_oe), 1);
    chk("R1 strobes", int'({irq_a, irq_b, dma_req, start_det, stop_det}), 0);
    // R2 write/readback
    wr(8'h5A); chk("R2 cfg_q", int'(cfg_q), 8'h5A);
    wr(8'h00);
    // R7 clock forced low
    wr(8'hA0); chk("R7 scl_o forced", int'(scl_o), 0);
    wr(8'h80); chk("R7 scl_o released", int'(scl_o), 1);
    // R8 data released
    wr(8'hC0); chk("R8 sda_oe off", int'(sda_oe), 0);
    wr(8'h80); chk("R8 sda_oe on", int'(sda_oe), 1);
    // R9 gating off: no conditions
    wr(8'h00); clr();
    do_start(); sda_in = 1'b1; tick(2); scl_in = 1'b0; do_stop();
    chk("R9 start gated", nst, 0); chk("R9 stop gated", nsp, 0);
    wr(8'h90); wr(8'h80); clr();
    do_start(); do_stop();
    chk("R9 start", nst, 1); chk("R9 stop", nsp, 1);
    // R9 start clears a partial frame
    do_start(); clock_pulse(); clock_pulse(); clock_pulse();
    clr(); do_start(); send_byte(8'h3C, 1'b1, 8'h11, 8'h22);
    chk("R9 realign buf", int'(rx_buf), 8'h22);
    chk("R9 realign irq_b", nb, 1);
    do_stop();
    // R10 init holds counter
    wr(8'h91); clr(); do_start(); send_byte(8'hF0, 1'b1, 8'h33, 8'h44); do_stop();
    chk("R10 no irq_a", na, 0); chk("R10 no irq_b", nb, 0);
    chk("R10 buf kept", int'(rx_buf), 8'h22);
    // R11 wait hold
    wr(8'h84); do_start(); send_byte(8'h81, 1'b1, 8'h00, 8'h00);
    chk("R11 scl held", int'(scl_o), 0);
    wr(8'h80); chk("R11 scl freed", int'(scl_o), 1);
    do_stop();
    // R12 arbitration stop
    wr(8'h88); tx_bit = 1'b1; do_start(); send_byte(8'h00, 1'b1, 8'h00, 8'h00);
    chk("R12 sda_oe dropped", int'(sda_oe), 0);
    wr(8'h80); tx_bit = 1'b0; chk("R12 sda_oe restored", int'(sda_oe), 1);
    do_stop();
    // R3 R4 R5 R6 R13 random frames
    for (int k = 0; k < 24; k++) begin
      bit m = 1'($urandom());
      bit ack = 1'($urandom());
      logic [7:0] d = 8'($urandom());
      logic [7:0] a = 8'($urandom());
      logic [7:0] b = ~a;
      dma_sel = ($urandom() % 2 == 0) ? 4'b1101 : 4'($urandom());
      wr({7'b1000000, m});
      do_start(); clr();
      send_byte(d, ack, a, b);
      chk(m ? "R4 irq_a" : "R3 irq_a", na, exp_a(m, ack));
      chk(m ? "R4 irq_b" : "R3 irq_b", nb, exp_b(m, ack));
      chk("R5 dma_req", nd, exp_d(m, ack, dma_sel));
      chk("R6 rx_buf", int'(rx_buf), int'(exp_buf(m, a, b)));
      chk("R13 pulse width", wid, 0);
      if ($urandom() % 2 == 0) do_stop();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule